// File: doc/BRIEF.md
# Hashed-Domain Packet Sequence Reorderer

This block keeps packets of the same flow in order while a pool of processing elements works on them in parallel and finishes them in any order. Each arriving descriptor brings a 104-bit flow 5-tuple and a packet tag. The tuple is folded by XOR into a domain index, so the tuple chooses an ordering domain rather than a processing element. The packet then takes that domain's next sequence number. The domain index and sequence number are returned to the arrival side in the same cycle, and they travel with the packet to its processing element.

When a processing element finishes a packet, it sends back the domain, the sequence number and the tag. Every domain keeps a 16-entry completion window. A domain releases only its oldest outstanding packet, and only once that packet has completed. One packet leaves per cycle. A round-robin arbiter chooses among the domains whose oldest packet is ready. Flows that hash to the same domain can still hold each other up. Flows in different domains never do.

Top module: `flow_domain_reorderer`

## Requirements
- R1: The domain of an arrival is computed as follows. Bit i of the tuple is XORed into bit (i mod 4) of a 4-bit fold. If the fold is 10 or more, 10 is subtracted. The result is shown on `arr_dom` in the same cycle.
- R2: Every domain has its own sequence counter. After reset the counter is 0. It advances by one, modulo 16, on each accepted arrival to that domain and on no other event. `arr_seq` shows the value that the current arrival would take.
- R3: `arr_ready` is low while the addressed domain holds 16 outstanding packets. An arrival offered while `arr_ready` is low is not taken and does not advance the counter. Once the domain releases a packet, the next arrival is taken with the wrapped number.
- R4: Within a domain, packets leave strictly in sequence order. A completed packet stays held while any older packet of its domain is incomplete.
- R5: A domain whose oldest packet is incomplete does not hold back releases from any other domain.
- R6: A completion that makes a domain's oldest packet releasable is sampled at one clock edge. When no other domain competes, the release appears on the outputs just after the next edge.
- R7: At most one packet is released per cycle. When several domains are ready, the grant goes to the first ready domain after the most recently granted one, counting cyclically upward.
- R8: A completion is ignored in three cases: its tag differs from the tag stored at arrival, its sequence number is not outstanding in the domain, or its domain index is 10 or more.
- R9: After reset, `rel_valid` is 0, every domain is empty, `arr_ready` is 1 and `arr_seq` is 0.
- R10: A release presents the domain, the sequence number and the tag that was recorded for that packet at arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arr_valid | input | 1 | Arrival descriptor present |
| arr_tuple | input | 104 | Flow 5-tuple of the arrival |
| arr_tag | input | 8 | Packet tag of the arrival |
| arr_ready | output | 1 | The addressed domain has room; the arrival is taken on this edge |
| arr_dom | output | 4 | Domain chosen for the arrival |
| arr_seq | output | 4 | Sequence number assigned to the arrival |
| cmp_valid | input | 1 | Completion notice present |
| cmp_dom | input | 4 | Domain of the completed packet |
| cmp_seq | input | 4 | Sequence number of the completed packet |
| cmp_tag | input | 8 | Tag of the completed packet |
| rel_valid | output | 1 | A packet is released in this cycle |
| rel_dom | output | 4 | Domain of the released packet |
| rel_seq | output | 4 | Sequence number of the released packet |
| rel_tag | output | 8 | Tag of the released packet |

## Verification
The arrival results (`arr_dom`, `arr_seq`, `arr_ready`) are combinational. The bench drives the descriptor just after a falling edge and reads these results one time step later, before the rising edge that takes the arrival. A release is registered. A completion sampled at rising edge e can appear on `rel_*` only after edge e+1. The bench therefore checks release outputs at the falling edge, once after e, where nothing may have left yet, and once after e+1, where the release is due. The round-robin case expects one release per consecutive falling edge from then on. The random phase compares every release against a model of each domain's outstanding window, kept in the bench.

// File: rtl/fdr_pkg.sv
`timescale 1ns/1ps
package fdr_pkg;

   localparam int TUPLE_W = 104;
   localparam int FOLD_MAX = 16;

   // Fold the tuple into w bits: bit i of the tuple lands in bit (i mod w)
   function automatic logic [FOLD_MAX-1:0] fold_tuple(input logic [TUPLE_W-1:0] t,
                                                      input int w);
      logic [FOLD_MAX-1:0] acc;
      acc = '0;
      for (int i = 0; i < TUPLE_W; i++) begin
         acc[i % w] = acc[i % w] ^ t[i];
      end
      return acc;
   endfunction

endpackage

// File: rtl/fdr_hash.sv
`timescale 1ns/1ps
module fdr_hash #(
   parameter int NUM_DOM = 10,
   parameter int DOM_W   = 4
) (
   input  logic [fdr_pkg::TUPLE_W-1:0] tuple,
   output logic [DOM_W-1:0]            dom
);
   logic [fdr_pkg::FOLD_MAX-1:0] fold_full;
   logic [DOM_W-1:0]             fold;

   assign fold_full = fdr_pkg::fold_tuple(tuple, DOM_W);
   assign fold      = fold_full[DOM_W-1:0];

   generate
      if ((1 << DOM_W) == NUM_DOM) begin : g_pow2
         // Every fold value is already a valid domain
         assign dom = fold;
      end else begin : g_reduce
         // The fold is below 2*NUM_DOM, so one conditional subtract is enough
         assign dom = (fold >= DOM_W'(NUM_DOM)) ? (fold - DOM_W'(NUM_DOM)) : fold;
      end
   endgenerate
endmodule

// File: rtl/fdr_domain.sv
`timescale 1ns/1ps
module fdr_domain #(
   parameter int WIN   = 16,
   parameter int SEQ_W = 4,
   parameter int TAG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arr_we,
   input  logic [TAG_W-1:0] arr_tag,
   input  logic             cmp_we,
   input  logic [SEQ_W-1:0] cmp_seq,
   input  logic [TAG_W-1:0] cmp_tag,
   input  logic             pop,
   output logic             full,
   output logic [SEQ_W-1:0] next_seq,
   output logic             head_ready,
   output logic [SEQ_W-1:0] head_seq,
   output logic [TAG_W-1:0] head_tag
);
   // Pointers carry one wrap bit above the slot index
   logic [SEQ_W:0]   wr_q, rd_q, occ;
   logic [WIN-1:0]   done_q, done_d;
   logic [TAG_W-1:0] tag_q [WIN];
   logic [SEQ_W-1:0] wr_slot, rd_slot, cmp_off;
   logic             empty, cmp_hit;

   assign wr_slot = wr_q[SEQ_W-1:0];
   assign rd_slot = rd_q[SEQ_W-1:0];
   assign occ     = wr_q - rd_q;
   assign empty   = (wr_q == rd_q);
   assign full    = (wr_slot == rd_slot) && (wr_q[SEQ_W] != rd_q[SEQ_W]);

   // A completion counts only if it is inside the outstanding window, carries the stored tag and is not a repeat
   assign cmp_off = cmp_seq - rd_slot;
   assign cmp_hit = cmp_we && ({1'b0, cmp_off} < occ) &&
                    (tag_q[cmp_seq] == cmp_tag) && !done_q[cmp_seq];

   assign next_seq   = wr_slot;
   assign head_ready = !empty && done_q[rd_slot];
   assign head_seq   = rd_slot;
   assign head_tag   = tag_q[rd_slot];

   always_comb begin
      done_d = done_q;
      if (cmp_hit) done_d[cmp_seq] = 1'b1;
      if (pop)     done_d[rd_slot] = 1'b0;
      if (arr_we)  done_d[wr_slot] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= '0;
         rd_q   <= '0;
         done_q <= '0;
      end else begin
         if (arr_we) wr_q <= wr_q + 1'b1;
         if (pop)    rd_q <= rd_q + 1'b1;
         done_q <= done_d;
      end
   end

   always_ff @(posedge clk) begin
      if (arr_we) tag_q[wr_slot] <= arr_tag;
   end

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> !full);

   a_r3_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= (SEQ_W+1)'(WIN));

   a_r4_pop_only_ready_head: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> head_ready);

   a_r2_seq_advances: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |=> (next_seq == $past(next_seq) + 1'b1));

   a_r2_seq_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !arr_we |=> $stable(next_seq));
endmodule

// File: rtl/fdr_rr_arb.sv
`timescale 1ns/1ps
module fdr_rr_arb #(
   parameter int N  = 10,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] grant_idx
);
   logic [IW-1:0] last_q;
   logic          found;
   int            cand;

   // Search starts one past the last winner and wraps around
   always_comb begin
      grant     = '0;
      grant_idx = '0;
      found     = 1'b0;
      cand      = 0;
      for (int i = 1; i <= N; i++) begin
         cand = int'(last_q) + i;
         if (cand >= N) cand = cand - N;
         if (!found && req[cand[IW-1:0]]) begin
            found                  = 1'b1;
            grant[cand[IW-1:0]]    = 1'b1;
            grant_idx              = cand[IW-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    last_q <= IW'(N-1);
      else if (|req) last_q <= grant_idx;
   end

   a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   a_r7_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);

   a_r7_no_idle_when_req: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|grant));

   a_r7_rotates_away: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(req) > 1) |-> !grant[last_q]);
endmodule

// File: rtl/flow_domain_reorderer.sv
`timescale 1ns/1ps
module flow_domain_reorderer #(
   parameter int NUM_DOM = 10,
   parameter int WIN     = 16,
   parameter int TAG_W   = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        arr_valid,
   input  logic [fdr_pkg::TUPLE_W-1:0] arr_tuple,
   input  logic [TAG_W-1:0]            arr_tag,
   output logic                        arr_ready,
   output logic [$clog2(NUM_DOM)-1:0]  arr_dom,
   output logic [$clog2(WIN)-1:0]      arr_seq,
   input  logic                        cmp_valid,
   input  logic [$clog2(NUM_DOM)-1:0]  cmp_dom,
   input  logic [$clog2(WIN)-1:0]      cmp_seq,
   input  logic [TAG_W-1:0]            cmp_tag,
   output logic                        rel_valid,
   output logic [$clog2(NUM_DOM)-1:0]  rel_dom,
   output logic [$clog2(WIN)-1:0]      rel_seq,
   output logic [TAG_W-1:0]            rel_tag
);
   localparam int DOM_W = $clog2(NUM_DOM);
   localparam int SEQ_W = $clog2(WIN);

   generate
      if (NUM_DOM < 2)               begin : g_chk_dom   $error("NUM_DOM must be at least 2"); end
      if (WIN != (1 << SEQ_W))       begin : g_chk_win   $error("WIN must be a power of two"); end
      if (DOM_W > fdr_pkg::FOLD_MAX) begin : g_chk_fold  $error("too many domains for the fold"); end
      if (TAG_W < 1)                 begin : g_chk_tag   $error("TAG_W must be positive"); end
   endgenerate

   logic [DOM_W-1:0]   hdom;
   logic [NUM_DOM-1:0] full_v, head_rdy, grant;
   logic [SEQ_W-1:0]   next_seq_a [NUM_DOM];
   logic [SEQ_W-1:0]   head_seq_a [NUM_DOM];
   logic [TAG_W-1:0]   head_tag_a [NUM_DOM];
   logic [DOM_W-1:0]   gidx;
   logic               take;

   fdr_hash #(.NUM_DOM(NUM_DOM), .DOM_W(DOM_W)) u_hash (
      .tuple (arr_tuple),
      .dom   (hdom)
   );

   assign arr_dom   = hdom;
   assign arr_ready = !full_v[hdom];
   assign arr_seq   = next_seq_a[hdom];
   assign take      = arr_valid && arr_ready;

   generate
      for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
         fdr_domain #(.WIN(WIN), .SEQ_W(SEQ_W), .TAG_W(TAG_W)) u_dom (
            .clk        (clk),
            .rst_n      (rst_n),
            .arr_we     (take && (hdom == DOM_W'(d))),
            .arr_tag    (arr_tag),
            .cmp_we     (cmp_valid && (cmp_dom == DOM_W'(d))),
            .cmp_seq    (cmp_seq),
            .cmp_tag    (cmp_tag),
            .pop        (grant[d]),
            .full       (full_v[d]),
            .next_seq   (next_seq_a[d]),
            .head_ready (head_rdy[d]),
            .head_seq   (head_seq_a[d]),
            .head_tag   (head_tag_a[d])
         );
      end
   endgenerate

   fdr_rr_arb #(.N(NUM_DOM), .IW(DOM_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (head_rdy),
      .grant     (grant),
      .grant_idx (gidx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_valid <= 1'b0;
         rel_dom   <= '0;
         rel_seq   <= '0;
         rel_tag   <= '0;
      end else begin
         rel_valid <= |grant;
         if (|grant) begin
            rel_dom <= gidx;
            rel_seq <= head_seq_a[gidx];
            rel_tag <= head_tag_a[gidx];
         end
      end
   end

   a_r1_dom_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      arr_valid |-> (arr_dom < DOM_W'(NUM_DOM)));

   a_r6_ready_head_released: assert property (@(posedge clk) disable iff (!rst_n)
      (|head_rdy) |=> rel_valid);

   a_r10_release_dom_range: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> (rel_dom < DOM_W'(NUM_DOM)));

   a_r3_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_valid && !arr_ready) |=> (arr_seq == $past(arr_seq)) || (arr_dom != $past(arr_dom)));
endmodule

// File: tb/flow_domain_reorderer_tb_top.sv
`timescale 1ns/1ps
module flow_domain_reorderer_tb_top;
   localparam int K  = 10;
   localparam int W  = 16;
   localparam int DW = 4;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arr_valid = 1'b0;
   logic [103:0]  arr_tuple = '0;
   logic [7:0]    arr_tag = '0;
   logic          arr_ready;
   logic [DW-1:0] arr_dom;
   logic [SW-1:0] arr_seq;
   logic          cmp_valid = 1'b0;
   logic [DW-1:0] cmp_dom = '0;
   logic [SW-1:0] cmp_seq = '0;
   logic [7:0]    cmp_tag = '0;
   logic          rel_valid;
   logic [DW-1:0] rel_dom;
   logic [SW-1:0] rel_seq;
   logic [7:0]    rel_tag;

   always #2.5 clk = ~clk;

   flow_domain_reorderer #(.NUM_DOM(K), .WIN(W), .TAG_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .arr_valid(arr_valid), .arr_tuple(arr_tuple), .arr_tag(arr_tag),
      .arr_ready(arr_ready), .arr_dom(arr_dom), .arr_seq(arr_seq),
      .cmp_valid(cmp_valid), .cmp_dom(cmp_dom), .cmp_seq(cmp_seq), .cmp_tag(cmp_tag),
      .rel_valid(rel_valid), .rel_dom(rel_dom), .rel_seq(rel_seq), .rel_tag(rel_tag)
   );

   int nchk = 0;
   int nerr = 0;
   int nrel = 0;

   int         m_wr [K];
   int         m_rd [K];
   logic [7:0] m_tag [K][W];
   bit         m_done [K][W];

   bit         lrv;
   int         ldom, lseq, ltag;

   function automatic int hash_of(logic [103:0] t);
      logic [3:0] h;
      h = '0;
      for (int i = 0; i < 104; i++) h[i % 4] = h[i % 4] ^ t[i];
      if (h >= 4'd10) h = h - 4'd10;
      return int'(h);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      bit ok;
      int expseq;
      @(negedge clk);
      lrv  = rel_valid;
      ldom = int'(rel_dom);
      lseq = int'(rel_seq);
      ltag = int'(rel_tag);
      if (rel_valid) begin
         ok = 1'b0;
         expseq = -1;
         if (ldom < K) begin
            expseq = m_rd[ldom] % W;
            if (m_wr[ldom] > m_rd[ldom])
               if (m_done[ldom][expseq] && lseq == expseq && ltag == int'(m_tag[ldom][expseq]))
                  ok = 1'b1;
         end
         check(ok, "R4 R10 release is oldest completed packet of its domain", lseq, expseq);
         if (ok) begin
            m_done[ldom][expseq] = 1'b0;
            m_rd[ldom]++;
            nrel++;
         end
      end
      arr_valid = 1'b0;
      cmp_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      arr_valid = 1'b0;
      cmp_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int d = 0; d < K; d++) begin
         m_wr[d] = 0;
         m_rd[d] = 0;
         for (int s = 0; s < W; s++) m_done[d][s] = 1'b0;
      end
   endtask

   // Call complete before arrive within one cycle: the design checks completions against the window as it stood before the edge
   task automatic complete(int d, int s, logic [7:0] tg);
      int cnt, off;
      cmp_valid = 1'b1;
      cmp_dom   = DW'(d);
      cmp_seq   = SW'(s);
      cmp_tag   = tg;
      if (d < K) begin
         cnt = m_wr[d] - m_rd[d];
         off = (s - (m_rd[d] % W) + W) % W;
         if (off < cnt && m_tag[d][s] == tg && !m_done[d][s]) m_done[d][s] = 1'b1;
      end
   endtask

   task automatic arrive(logic [103:0] t, logic [7:0] tg, output bit acc);
      int d, es;
      bit er;
      arr_valid = 1'b1;
      arr_tuple = t;
      arr_tag   = tg;
      #1;
      d  = hash_of(t);
      es = m_wr[d] % W;
      er = (m_wr[d] - m_rd[d]) < W;
      check(int'(arr_dom) == d, "R1 domain from XOR fold", int'(arr_dom), d);
      check(int'(arr_seq) == es, "R2 per-domain sequence number", int'(arr_seq), es);
      check(arr_ready == er, "R3 arrival ready vs window fill", int'(arr_ready), int'(er));
      acc = er;
      if (er) begin
         m_tag[d][es]  = tg;
         m_done[d][es] = 1'b0;
         m_wr[d]++;
      end
   endtask

   task automatic expect_rel(bit v, int d, int s, string req);
      check(lrv == v, req, int'(lrv), int'(v));
      if (v && lrv) begin
         check(ldom == d, req, ldom, d);
         check(lseq == s, req, lseq, s);
      end
   endtask

   initial begin : wdog
      repeat (100000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog R4 run did not finish actual=%0d expected=%0d", 100000, 0);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin : main
      bit acc;
      logic [103:0] t;
      void'($urandom(32'd2024));

      // R9 reset state
      do_reset();
      step();
      check(rel_valid == 1'b0, "R9 no release after reset", int'(rel_valid), 0);
      arr_tuple = 104'd6;
      #1;
      check(arr_ready == 1'b1, "R9 ready after reset", int'(arr_ready), 1);
      check(arr_seq == '0, "R9 sequence zero after reset", int'(arr_seq), 0);

      // R1 and R2: a few folds and independent counters
      arrive(104'hF, 8'h01, acc); step();
      arrive({26{4'h3}}, 8'h02, acc); step();
      arrive(104'hDEAD_BEEF_0123_4567_89AB_CDEF_55, 8'h03, acc); step();
      arrive(104'd7, 8'h04, acc); step();
      arrive(104'd7, 8'h05, acc); step();
      arrive(104'd2, 8'h06, acc); step();

      // R4 and R6: hold behind an incomplete head, then the release latency
      do_reset();
      arrive(104'd3, 8'hA0, acc); step();
      arrive(104'd3, 8'hA1, acc); step();
      arrive(104'd3, 8'hA2, acc); step();
      complete(3, 1, 8'hA1); step();
      expect_rel(1'b0, 0, 0, "R4 seq1 held behind seq0");
      step(); expect_rel(1'b0, 0, 0, "R4 seq1 held behind seq0");
      step(); expect_rel(1'b0, 0, 0, "R4 seq1 held behind seq0");
      complete(3, 0, 8'hA0); step();
      expect_rel(1'b0, 0, 0, "R6 not released one edge after completion");
      step(); expect_rel(1'b1, 3, 0, "R6 released after second edge");
      check(ltag == 8'hA0, "R10 released tag", ltag, 8'hA0);
      step(); expect_rel(1'b1, 3, 1, "R4 next in order follows");
      step(); expect_rel(1'b0, 0, 0, "R4 seq2 still incomplete");

      // R5: another domain proceeds while domain 3 stalls
      arrive(104'd7, 8'hB0, acc); step();
      complete(7, 0, 8'hB0); step();
      step(); expect_rel(1'b1, 7, 0, "R5 other domain not blocked");

      // R8: ignored completions
      complete(3, 2, 8'h55); step();
      step(); step(); expect_rel(1'b0, 0, 0, "R8 tag mismatch ignored");
      complete(3, 3, 8'hA2); step();
      step(); step(); expect_rel(1'b0, 0, 0, "R8 sequence not outstanding ignored");
      complete(12, 2, 8'hA2); step();
      step(); step(); expect_rel(1'b0, 0, 0, "R8 domain out of range ignored");
      complete(3, 2, 8'hA2); step();
      step(); expect_rel(1'b1, 3, 2, "R8 valid completion accepted");

      // R3: fill, refuse, wrap
      do_reset();
      for (int i = 0; i < W; i++) begin
         arrive(104'd4, 8'(8'h40 + i), acc); step();
      end
      arrive(104'd4, 8'hEE, acc);
      check(arr_ready == 1'b0, "R3 full domain refuses", int'(arr_ready), 0);
      step();
      complete(4, 0, 8'h40); step();
      step(); expect_rel(1'b1, 4, 0, "R3 head released from full domain");
      arrive(104'd4, 8'h50, acc);
      check(acc == 1'b1 && arr_seq == 4'd0, "R3 wrapped sequence after refusal", int'(arr_seq), 0);
      step();
      arrive(104'd4, 8'h51, acc); step();
      for (int s = W - 1; s >= 1; s--) begin
         complete(4, s, 8'(8'h40 + s)); step();
      end
      complete(4, 0, 8'h50); step();
      repeat (24) step();
      check(m_rd[4] == 17, "R3 wrapped window drained in order", m_rd[4], 17);

      // R7: round robin between domains 2 and 5
      do_reset();
      for (int i = 0; i < 3; i++) begin
         arrive(104'd2, 8'(8'h20 + i), acc); step();
         arrive(104'd5, 8'(8'h50 + i), acc); step();
      end
      complete(2, 1, 8'h21); step();
      complete(2, 2, 8'h22); step();
      complete(5, 1, 8'h51); step();
      complete(5, 2, 8'h52); step();
      complete(5, 0, 8'h50); step();
      complete(2, 0, 8'h20); step();
      expect_rel(1'b1, 5, 0, "R7 first ready domain");
      step(); expect_rel(1'b1, 2, 0, "R7 rotate to domain 2");
      step(); expect_rel(1'b1, 5, 1, "R7 rotate to domain 5");
      step(); expect_rel(1'b1, 2, 1, "R7 rotate to domain 2");
      step(); expect_rel(1'b1, 5, 2, "R7 rotate to domain 5");
      step(); expect_rel(1'b1, 2, 2, "R7 rotate to domain 2");
      step(); expect_rel(1'b0, 0, 0, "R7 nothing left");

      // Random phase
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         if ($urandom % 2 == 0) begin
            int d, o, s;
            d = int'($urandom % K);
            if (m_wr[d] > m_rd[d]) begin
               o = int'($urandom % (m_wr[d] - m_rd[d]));
               s = (m_rd[d] + o) % W;
               if ($urandom % 8 == 0) complete(d, s, m_tag[d][s] ^ 8'h01);
               else if (!m_done[d][s]) complete(d, s, m_tag[d][s]);
            end
         end
         if ($urandom % 3 != 0) begin
            if ($urandom % 4 == 0) t = 104'($urandom % K);
            else t = {$urandom, $urandom, $urandom, 8'($urandom)};
            arrive(t, 8'($urandom), acc);
         end
         step();
      end
      for (int n = 0; n < 2000; n++) begin
         bit found;
         found = 1'b0;
         for (int d = 0; d < K; d++) begin
            for (int o = 0; o < W; o++) begin
               if (!found && o < m_wr[d] - m_rd[d] && !m_done[d][(m_rd[d] + o) % W]) begin
                  found = 1'b1;
                  complete(d, (m_rd[d] + o) % W, m_tag[d][(m_rd[d] + o) % W]);
               end
            end
         end
         step();
      end
      for (int d = 0; d < K; d++)
         check(m_wr[d] == m_rd[d], "R4 R5 every domain drained", m_wr[d] - m_rd[d], 0);

      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule